// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine takes packets that a host pushes through a write command and copies each one into a memory buffer. A ring of descriptors held in memory names the buffers. Each descriptor is 8 bytes, and its first word holds the buffer's destination address. The engine owns the write index of the ring, together with a wrap flag. Software owns the read index and its wrap flag, and drives both in from a CPU register bank. From the two indices the engine derives the number of free descriptors.

Each command carries a 16-bit address. Bits [15:13] choose the path, and the value 3'b100 selects the transmit path. Bits [12:0] give the packet length in 32-bit words. The engine checks the command before it accepts the packet:

- If no descriptor is free, the packet is refused with an overflow interrupt.
- If the packet is longer than one buffer, it is refused with an oversize interrupt. A buffer holds `cfg_unit` × 64 bytes.

The data words of a refused packet are still consumed from the stream, so the stream stays aligned for the next command. When a packet is accepted, the engine does the following:

- It reads the descriptor.
- It writes the words to consecutive addresses.
- It advances the write index.
- It raises a completion interrupt.

Memory is reached through a generic request/ready port, with a separate read-response strobe.

Top module: `txring_dma`

## Requirements
- R1: After `rst_n` is released, the following are all zero: `hw_wptr`, `hw_wptr_wrap`, `irq_stat` and `irq`. `cmd_ready` is 1.
- R2: `free_cnt` equals N − ((wptr − rptr) mod N), where N is `cfg_num`. When the two indices are equal, it is N if the wrap flags match and 0 if they differ. It follows a change of `sw_rptr` or `sw_rptr_wrap` on the next cycle.
- R3: For an accepted packet, the engine issues one descriptor read (`mem_we`=0) at `cfg_base + 8*hw_wptr`.
- R4: The words of an accepted packet are written in stream order. Word k goes to address D + 4k, where D is the descriptor word returned by the read. Exactly the number of words given in `cmd_addr[12:0]` is written.
- R5: A transmit command offered while `free_cnt` is 0 sets `irq_stat[1]`. Its words are consumed without any memory write, and the write index stays unchanged. This check takes precedence over the size check.
- R6: A transmit command longer than `cfg_unit*16` words sets `irq_stat[2]` and is consumed without any memory write. A length exactly equal to the limit is accepted, and so is a length of 0.
- R7: Once an accepted packet is complete, `hw_wptr` advances by one and `irq_stat[0]` is set. From N−1, `hw_wptr` returns to 0 and `hw_wptr_wrap` toggles.
- R8: Each bit of `irq_stat` stays set until a cycle in which the matching bit of `irq_clr` is 1. That cycle clears it.
- R9: `irq[k]` is 1 exactly when `irq_stat[k]` and `irq_mask[k]` are both 1.
- R10: A one-cycle pulse on `dma_rst` returns `hw_wptr` and `hw_wptr_wrap` to 0. It does not change `irq_stat`.
- R11: A command whose `cmd_addr[15:13]` is not 3'b100 is accepted but has no effect: no memory access, no status bit and no index change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dma_rst | input | 1 | Engine reset pulse (write index, wrap flag, state) |
| cfg_base | input | AW | Descriptor table base, 8-byte aligned |
| cfg_num | input | IW | Descriptor count N |
| cfg_unit | input | UW | Buffer size in 64-byte units |
| sw_rptr | input | IW | Software read index |
| sw_rptr_wrap | input | 1 | Software read wrap flag |
| irq_mask | input | 3 | Interrupt enables, 1 = pass |
| irq_clr | input | 3 | Write-1-to-clear strobes for irq_stat |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_addr | input | 16 | [15:13] path select, [12:0] length in words |
| dat_valid | input | 1 | Data word offered |
| dat_ready | output | 1 | Data word taken |
| dat_data | input | DW | Data word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | AW | Read data (descriptor address) |
| hw_wptr | output | IW | Hardware write index |
| hw_wptr_wrap | output | 1 | Write wrap flag |
| free_cnt | output | IW | Free descriptor count |
| irq_stat | output | 3 | Status: [0] done, [1] overflow, [2] oversize |
| irq | output | 3 | Masked interrupts |

## Verification
The bench builds the engine with IW=3 and runs a ring of five descriptors, which is not a power of two. This lets a handful of packets fill the ring, reach the zero-free state with differing wrap flags, and wrap the write index many times. The buffer unit is set to 2, so the oversize limit is only 32 words. Lengths just on and just past that limit therefore come up often, as do packets refused for both reasons at once. Random memory back-pressure stretches both the descriptor fetch and the data copy.

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int UW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_rst,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_num,
  input  logic [UW-1:0] cfg_unit,
  input  logic [IW-1:0] sw_rptr,
  input  logic          sw_rptr_wrap,
  input  logic [2:0]    irq_mask,
  input  logic [2:0]    irq_clr,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [15:0]   cmd_addr,
  input  logic          dat_valid,
  output logic          dat_ready,
  input  logic [DW-1:0] dat_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic [IW-1:0] hw_wptr,
  output logic          hw_wptr_wrap,
  output logic [IW-1:0] free_cnt,
  output logic [2:0]    irq_stat,
  output logic [2:0]    irq
);
  localparam int LW = 13;
  localparam logic [2:0] TX_PATH = 3'b100;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RESP, S_COPY, S_DONE, S_DRAIN} st_t;

  st_t           st;
  logic [LW-1:0] left;
  logic [AW-1:0] dst;
  logic [IW:0]   used;

  wire [IW:0]   n_ext   = {1'b0, cfg_num};
  wire [LW-1:0] pkt_len = cmd_addr[LW-1:0];
  wire          is_tx   = cmd_addr[15:13] == TX_PATH;
  wire          take    = cmd_valid && cmd_ready;
  wire          no_room = free_cnt == '0;
  wire          too_big = {{(UW+4){1'b0}}, pkt_len} > {{LW{1'b0}}, cfg_unit, 4'b0000};
  wire          beat    = dat_valid && dat_ready;
  wire          last_ix = hw_wptr == IW'(cfg_num - 1'b1);
  wire [AW-1:0] bd_addr = cfg_base + AW'({hw_wptr, 3'b000});

  always_comb begin
    if (hw_wptr == sw_rptr)
      used = (hw_wptr_wrap != sw_rptr_wrap) ? n_ext : '0;
    else if (hw_wptr > sw_rptr)
      used = {1'b0, hw_wptr} - {1'b0, sw_rptr};
    else
      used = {1'b0, hw_wptr} + n_ext - {1'b0, sw_rptr};
  end

  assign free_cnt  = IW'(n_ext - used);
  assign cmd_ready = st == S_IDLE;
  assign mem_req   = (st == S_FETCH) || (st == S_COPY && dat_valid);
  assign mem_we    = st == S_COPY;
  assign mem_addr  = (st == S_COPY) ? dst : bd_addr;
  assign mem_wdata = dat_data;
  assign dat_ready = (st == S_COPY && mem_ready) || st == S_DRAIN;

  wire set_done = st == S_DONE;
  wire set_ovf  = take && is_tx && no_room;
  wire set_big  = take && is_tx && !no_room && too_big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_stat <= '0;
    else        irq_stat <= (irq_stat & ~irq_clr) | {set_big, set_ovf, set_done};
  end

  assign irq = irq_stat & irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      hw_wptr      <= '0;
      hw_wptr_wrap <= 1'b0;
      left         <= '0;
      dst          <= '0;
    end else if (dma_rst) begin
      st           <= S_IDLE;
      hw_wptr      <= '0;
      hw_wptr_wrap <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take && is_tx) begin
          left <= pkt_len;
          if (no_room || too_big) st <= (pkt_len != '0) ? S_DRAIN : S_IDLE;
          else                    st <= S_FETCH;
        end
        S_FETCH: if (mem_ready) st <= S_RESP;
        S_RESP: if (mem_rvalid) begin
          dst <= mem_rdata;
          st  <= (left == '0) ? S_DONE : S_COPY;
        end
        S_COPY: if (beat) begin
          dst  <= dst + AW'(4);
          left <= left - 1'b1;
          if (left == LW'(1)) st <= S_DONE;
        end
        S_DONE: begin
          hw_wptr <= last_ix ? '0 : hw_wptr + 1'b1;
          if (last_ix) hw_wptr_wrap <= ~hw_wptr_wrap;
          st <= S_IDLE;
        end
        S_DRAIN: if (beat) begin
          left <= left - 1'b1;
          if (left == LW'(1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
  parameter int AW = 32,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_rst,
  input logic [AW-1:0] cfg_base,
  input logic [IW-1:0] cfg_num,
  input logic          dat_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [IW-1:0] hw_wptr,
  input logic          hw_wptr_wrap,
  input logic [IW-1:0] free_cnt
);
  a_r3_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> mem_addr == cfg_base + AW'({hw_wptr, 3'b000}));

  a_r4_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (dat_valid && mem_addr[1:0] == 2'b00));

  a_r7_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(dma_rst) && hw_wptr != $past(hw_wptr)) |->
      (hw_wptr == $past(hw_wptr) + 1'b1) || (hw_wptr == '0));

  a_r7_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wptr_wrap != $past(hw_wptr_wrap)) |-> hw_wptr == '0);

  a_r2_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= cfg_num);

  a_r10_dma_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_rst) |-> (hw_wptr == '0 && !hw_wptr_wrap));
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_rst(dma_rst), .cfg_base(cfg_base),
  .cfg_num(cfg_num), .dat_valid(dat_valid), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .hw_wptr(hw_wptr),
  .hw_wptr_wrap(hw_wptr_wrap), .free_cnt(free_cnt)
);

// File: tb/txring_dma_bench.sv
`timescale 1ns/1ps
module txring_dma_bench;
  localparam int AW = 32, DW = 32, IW = 3, UW = 8;
  localparam int N = 5, UNIT = 2;
  localparam logic [31:0] BASE = 32'h0000_8000;

  logic clk = 0, rst_n = 0, dma_rst = 0;
  logic [AW-1:0] cfg_base = BASE;
  logic [IW-1:0] cfg_num = IW'(N);
  logic [UW-1:0] cfg_unit = UW'(UNIT);
  logic [IW-1:0] sw_rptr = '0;
  logic sw_rptr_wrap = 0;
  logic [2:0] irq_mask = 3'b111, irq_clr = '0;
  logic cmd_valid = 0, cmd_ready;
  logic [15:0] cmd_addr = '0;
  logic dat_valid = 0, dat_ready;
  logic [DW-1:0] dat_data = '0;
  logic mem_req, mem_we, mem_ready = 0, mem_rvalid = 0;
  logic [AW-1:0] mem_addr, mem_rdata = '0;
  logic [DW-1:0] mem_wdata;
  logic [IW-1:0] hw_wptr, free_cnt;
  logic hw_wptr_wrap;
  logic [2:0] irq_stat, irq;

  txring_dma #(.AW(AW), .DW(DW), .IW(IW), .UW(UW)) u_txring_dma (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  int ew = 0, ewf = 0, r = 0, rf = 0;
  int estat = 0;
  logic [31:0] exp_wr_addr = '0;
  logic [15:0] tag = '0;
  int beat_idx = 0, seen_beats = 0, bad_beats = 0, bad_reads = 0;

  function automatic logic [31:0] dst_of(int i);
    return 32'h0001_0000 + 32'(i) * 32'h400;
  endfunction

  function automatic int exp_free();
    int u;
    if (ew == r) u = (ewf != rf) ? N : 0;
    else if (ew > r) u = ew - r;
    else u = ew + N - r;
    return N - u;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req && !mem_we && mem_ready) begin
      if (mem_addr != BASE + 32'(ew) * 8) bad_reads++;
      mem_rvalid <= 1'b1;
      mem_rdata  <= dst_of(int'((mem_addr - BASE) >> 3));
    end
    if (mem_req && mem_we && mem_ready) begin
      if (mem_addr != exp_wr_addr || mem_wdata != {tag, 16'(beat_idx)}) bad_beats++;
      exp_wr_addr = exp_wr_addr + 4;
      beat_idx++;
      seen_beats++;
    end
    mem_ready <= ($urandom % 4) != 0;
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, int'(hw_wptr), ew);
    chk(req, int'(hw_wptr_wrap), ewf);
    chk("R2", int'(free_cnt), exp_free());
    chk(req, int'(irq_stat), estat);
    chk("R9", int'(irq), estat & int'(irq_mask));
  endtask

  task automatic send(bit tx, int len);
    bit acc, ovf, big;
    string req;
    acc = tx && exp_free() > 0 && len <= UNIT * 16;
    ovf = tx && exp_free() == 0;
    big = tx && !ovf && len > UNIT * 16;
    tag = tag + 1'b1;
    exp_wr_addr = dst_of(ew);
    beat_idx = 0; seen_beats = 0; bad_beats = 0;
    cmd_addr = {tx ? 3'b100 : 3'(1 + $urandom % 3), 13'(len)};
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    if (tx) begin
      for (int k = 0; k < len; k++) begin
        dat_data = {tag, 16'(k)};
        dat_valid = 1;
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
      end
      dat_valid = 0;
    end
    while (!cmd_ready) @(negedge clk);
    if (acc) begin
      ew++;
      if (ew == N) begin ew = 0; ewf ^= 1; end
      estat |= 1;
      req = "R7";
    end else if (ovf) begin estat |= 2; req = "R5"; end
    else if (big) begin estat |= 4; req = "R6"; end
    else req = "R11";
    chk("R4", seen_beats, acc ? len : 0);
    chk("R4", bad_beats, 0);
    check_state(req);
  endtask

  task automatic set_rptr(int nr, int nrf);
    r = nr; rf = nrf;
    sw_rptr = IW'(r); sw_rptr_wrap = rf[0];
    @(negedge clk);
    chk("R2", int'(free_cnt), exp_free());
  endtask

  task automatic consume(int k);
    int nr = r, nrf = rf;
    for (int j = 0; j < k; j++) begin
      nr++;
      if (nr == N) begin nr = 0; nrf ^= 1; end
    end
    set_rptr(nr, nrf);
  endtask

  task automatic clear(logic [2:0] bits);
    irq_clr = bits;
    @(negedge clk);
    irq_clr = '0;
    estat &= ~int'(bits);
    @(negedge clk);
    check_state("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1");
    chk("R1", int'(cmd_ready), 1);

    send(1, 3);
    send(1, UNIT * 16);
    send(1, UNIT * 16 + 1);
    send(1, 0);
    send(0, 7);
    clear(3'b101);
    send(1, 1);
    send(1, 2);
    chk("R7", ewf, 1);
    send(1, UNIT * 16 + 5);
    send(1, 0);
    clear(3'b010);
    irq_mask = 3'b010;
    send(1, 4);
    irq_mask = 3'b101;
    @(negedge clk);
    check_state("R9");
    irq_mask = 3'b111;
    consume(2);
    send(1, 6);
    clear(3'b111);

    for (int it = 0; it < 160; it++) begin
      case ($urandom % 5)
        0, 1: begin
          int l = ($urandom % 4 == 0) ? UNIT * 16 + int'($urandom % 3) : int'($urandom % (UNIT * 16 + 1));
          send(1, l);
        end
        2: consume(int'($urandom % (N - exp_free() + 1)));
        3: clear(3'($urandom));
        default: if ($urandom % 3 == 0) send(0, int'($urandom % 8)); else send(1, int'($urandom % 5));
      endcase
    end

    send(1, 2);
    dma_rst = 1;
    @(negedge clk);
    dma_rst = 0;
    ew = 0; ewf = 0;
    @(negedge clk);
    check_state("R10");
    set_rptr(0, 0);
    send(1, 3);
    chk("R3", bad_reads, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule